// File: doc/BRIEF.md
# Day/Hour/Minute/Second Timekeeper Core

This core keeps wall-clock time as four separate counters (seconds, minutes, hours and days) that advance once for every pulse on a one-second tick input. A second set of registers holds an alarm time, and the core raises a one-cycle alarm pulse when a tick brings the live counters into agreement with all four alarm fields. The tick comes from a companion prescaler. The interrupt status and enable logic also live in that companion block, and it reads the clock-rate field that this core exposes.

Software uses a 16-bit register bus with byte addresses on word boundaries. Hour and minute share one word, with the hour in the upper byte and the minute in the lower byte. The day counter has its own word and its own alarm word. A control word carries a run enable and a clock-rate code. Counters can be written while they are running, and a write lands exactly as given.

Top module: `rtc_dhms_core`

## Requirements
- R1: After reset every counter, every alarm field and every control bit reads zero, and `alarm_o` and `rate_sel_o` are zero.
- R2: With the run enable set, each cycle with `tick_i` high and no time-register write advances the seconds count by one. Cycles without a tick change no counter.
- R3: On an advancing tick, a seconds value of 59 or more becomes 0 and carries into minutes. A minute value of 59 or more becomes 0 and carries into hours. An hour value of 23 or more becomes 0 and carries into days.
- R4: A read (`bus_sel_i` high, `bus_wr_i` low) returns data in the same cycle, decoded on address bits 5:2. 0x00 returns hour in bits 12:8 and minute in bits 5:0. 0x04 returns seconds in bits 5:0. 0x08 and 0x0C return the alarm hour/minute and alarm seconds in the same layouts. 0x10 returns control. 0x20 returns the days. 0x24 returns the alarm days. Any other address, and any cycle that is not a read, returns 0.
- R5: A write to 0x00, 0x04 or 0x20 loads that counter with the written bits on the next edge. The hour takes bits 12:8, minute and seconds take bits 5:0, and the days take bits DAY_W-1:0. A tick arriving in the same cycle is discarded, so no carry occurs.
- R6: While control bit 7 (run enable) is clear, ticks are ignored and all counters hold.
- R7: The control word stores bit 7 and the rate code in bits 6:5, and reads back exactly those bits with the others zero. `rate_sel_o` carries bits 6:5 (0 = 32768 Hz, 1 = 32000 Hz, 2 = 38400 Hz).
- R8: The alarm condition holds only when days, hours, minutes and seconds all equal their alarm fields.
- R9: `alarm_o` is high for exactly one cycle: the cycle after an advancing tick edge that leaves the alarm condition true. Making the fields equal by a bus write, with no tick, produces no pulse.
- R10: The day counter is DAY_W bits wide (1 to 16; 9 for a reduced build) and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance strobe, one cycle wide |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address of the register word |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the read |
| rate_sel_o | output | 2 | Stored clock-rate code for the prescaler |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The assertions assume that the tick and the bus strobes are sampled only at rising edges and are free of unknown values once reset is released. They also assume that the inputs are held idle while reset is asserted, so that no write or tick attempt straddles reset release. The stimulus follows these rules. It changes inputs on the falling edge, keeps every strobe low during reset, and presents each write as a one-cycle strobe. This still allows the tick to coincide with a write, which exercises the collision rule.

// File: rtl/rtc_dhms_pkg.sv
package rtc_dhms_pkg;

   localparam int BUS_AW  = 6;
   localparam int BUS_DW  = 16;
   localparam int SEC_W   = 6;
   localparam int MIN_W   = 6;
   localparam int HR_W    = 5;
   localparam int SEC_TOP = 59;
   localparam int MIN_TOP = 59;
   localparam int HR_TOP  = 23;

   // word index = byte address bits 5:2
   localparam logic [3:0] W_HM   = 4'h0;
   localparam logic [3:0] W_SEC  = 4'h1;
   localparam logic [3:0] W_AHM  = 4'h2;
   localparam logic [3:0] W_ASEC = 4'h3;
   localparam logic [3:0] W_CTL  = 4'h4;
   localparam logic [3:0] W_DAY  = 4'h8;
   localparam logic [3:0] W_ADAY = 4'h9;

   typedef struct packed {
      logic [HR_W-1:0]  hr;
      logic [MIN_W-1:0] mn;
      logic [SEC_W-1:0] sc;
   } hms_t;

endpackage

// File: rtl/rtc_dhms_digit.sv
module rtc_dhms_digit #(
   parameter int W       = 6,
   parameter int LIMIT   = 59,
   parameter bit BOUNDED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         inc_i,
   output logic [W-1:0] val_o,
   output logic         carry_o
);

   logic [W-1:0] val_q;
   logic         at_top;

   generate
      if (BOUNDED) begin : g_bounded
         assign at_top = (val_q >= W'(LIMIT));
      end else begin : g_full
         assign at_top = &val_q;
      end
   endgenerate

   assign carry_o = inc_i & at_top;
   assign val_o   = val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      val_q <= '0;
      else if (load_i) val_q <= load_val_i;
      else if (inc_i)  val_q <= at_top ? '0 : val_q + 1'b1;
   end

endmodule

// File: rtl/rtc_dhms_chain.sv
module rtc_dhms_chain
   import rtc_dhms_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             ld_hm_i,
   input  logic             ld_sec_i,
   input  logic             ld_day_i,
   input  hms_t             ld_val_i,
   input  logic [DAY_W-1:0] ld_day_val_i,
   output hms_t             now_o,
   output logic [DAY_W-1:0] day_o
);

   logic c_sec, c_min, c_hr, c_day;
   logic unused_cday;

   rtc_dhms_digit #(.W(SEC_W), .LIMIT(SEC_TOP), .BOUNDED(1'b1)) u_sec (
      .clk(clk), .rst_n(rst_n), .load_i(ld_sec_i), .load_val_i(ld_val_i.sc),
      .inc_i(step_i), .val_o(now_o.sc), .carry_o(c_sec));

   rtc_dhms_digit #(.W(MIN_W), .LIMIT(MIN_TOP), .BOUNDED(1'b1)) u_min (
      .clk(clk), .rst_n(rst_n), .load_i(ld_hm_i), .load_val_i(ld_val_i.mn),
      .inc_i(c_sec), .val_o(now_o.mn), .carry_o(c_min));

   rtc_dhms_digit #(.W(HR_W), .LIMIT(HR_TOP), .BOUNDED(1'b1)) u_hr (
      .clk(clk), .rst_n(rst_n), .load_i(ld_hm_i), .load_val_i(ld_val_i.hr),
      .inc_i(c_min), .val_o(now_o.hr), .carry_o(c_hr));

   rtc_dhms_digit #(.W(DAY_W), .LIMIT(0), .BOUNDED(1'b0)) u_day (
      .clk(clk), .rst_n(rst_n), .load_i(ld_day_i), .load_val_i(ld_day_val_i),
      .inc_i(c_hr), .val_o(day_o), .carry_o(c_day));

   assign unused_cday = c_day;

endmodule

// File: rtl/rtc_dhms_regs.sv
module rtc_dhms_regs
   import rtc_dhms_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [BUS_AW-1:0] bus_addr_i,
   input  logic [BUS_DW-1:0] bus_wdata_i,
   output logic [BUS_DW-1:0] bus_rdata_o,
   input  hms_t              now_i,
   input  logic [DAY_W-1:0]  day_i,
   output logic              ld_hm_o,
   output logic              ld_sec_o,
   output logic              ld_day_o,
   output logic              run_o,
   output logic [1:0]        rate_o,
   output hms_t              alm_o,
   output logic [DAY_W-1:0]  alm_day_o
);

   logic [3:0]  word;
   logic        wr_en, rd_en;
   logic        run_q;
   logic [1:0]  rate_q;
   hms_t        alm_q;
   logic [DAY_W-1:0] aday_q;
   logic        unused_in;

   assign word  = bus_addr_i[BUS_AW-1:2];
   assign wr_en = bus_sel_i & bus_wr_i;
   assign rd_en = bus_sel_i & ~bus_wr_i;

   assign ld_hm_o  = wr_en && (word == W_HM);
   assign ld_sec_o = wr_en && (word == W_SEC);
   assign ld_day_o = wr_en && (word == W_DAY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         rate_q <= '0;
         alm_q  <= '0;
         aday_q <= '0;
      end else if (wr_en) begin
         case (word)
            W_CTL:  begin
               run_q  <= bus_wdata_i[7];
               rate_q <= bus_wdata_i[6:5];
            end
            W_AHM:  begin
               alm_q.hr <= bus_wdata_i[8 +: HR_W];
               alm_q.mn <= bus_wdata_i[MIN_W-1:0];
            end
            W_ASEC: alm_q.sc <= bus_wdata_i[SEC_W-1:0];
            W_ADAY: aday_q   <= bus_wdata_i[DAY_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (rd_en) begin
         case (word)
            W_HM:   bus_rdata_o = {3'b0, now_i.hr, 2'b0, now_i.mn};
            W_SEC:  bus_rdata_o = BUS_DW'(now_i.sc);
            W_AHM:  bus_rdata_o = {3'b0, alm_q.hr, 2'b0, alm_q.mn};
            W_ASEC: bus_rdata_o = BUS_DW'(alm_q.sc);
            W_CTL:  bus_rdata_o = {8'b0, run_q, rate_q, 5'b0};
            W_DAY:  bus_rdata_o = BUS_DW'(day_i);
            W_ADAY: bus_rdata_o = BUS_DW'(aday_q);
            default: bus_rdata_o = '0;
         endcase
      end
   end

   assign run_o     = run_q;
   assign rate_o    = rate_q;
   assign alm_o     = alm_q;
   assign alm_day_o = aday_q;
   assign unused_in = ^{bus_addr_i[1:0], bus_wdata_i};

endmodule

// File: rtl/rtc_dhms_match.sv
module rtc_dhms_match
   import rtc_dhms_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  hms_t             now_i,
   input  logic [DAY_W-1:0] day_i,
   input  hms_t             alm_i,
   input  logic [DAY_W-1:0] alm_day_i,
   output logic             alarm_o
);

   logic stepped_q;
   logic hit;

   always_ff @(posedge clk) begin
      if (!rst_n) stepped_q <= 1'b0;
      else        stepped_q <= step_i;
   end

   assign hit     = (now_i == alm_i) && (day_i == alm_day_i);
   assign alarm_o = stepped_q & hit;

endmodule

// File: rtl/rtc_dhms_core.sv
module rtc_dhms_core
   import rtc_dhms_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [BUS_AW-1:0] bus_addr_i,
   input  logic [BUS_DW-1:0] bus_wdata_i,
   output logic [BUS_DW-1:0] bus_rdata_o,
   output logic [1:0]        rate_sel_o,
   output logic              alarm_o
);

   initial begin
      assert (DAY_W >= 1 && DAY_W <= BUS_DW)
         else $error("DAY_W must lie in 1..%0d", BUS_DW);
   end

   hms_t             now_w, alm_w, ld_val_w;
   logic [DAY_W-1:0] day_w, aday_w;
   logic             ld_hm_w, ld_sec_w, ld_day_w, run_w, step_w;

   assign ld_val_w.hr = bus_wdata_i[8 +: HR_W];
   assign ld_val_w.mn = bus_wdata_i[MIN_W-1:0];
   assign ld_val_w.sc = bus_wdata_i[SEC_W-1:0];
   assign step_w = tick_i & run_w & ~(ld_hm_w | ld_sec_w | ld_day_w);

   rtc_dhms_regs #(.DAY_W(DAY_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .now_i(now_w), .day_i(day_w), .ld_hm_o(ld_hm_w), .ld_sec_o(ld_sec_w),
      .ld_day_o(ld_day_w), .run_o(run_w), .rate_o(rate_sel_o),
      .alm_o(alm_w), .alm_day_o(aday_w));

   rtc_dhms_chain #(.DAY_W(DAY_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .step_i(step_w), .ld_hm_i(ld_hm_w),
      .ld_sec_i(ld_sec_w), .ld_day_i(ld_day_w), .ld_val_i(ld_val_w),
      .ld_day_val_i(bus_wdata_i[DAY_W-1:0]), .now_o(now_w), .day_o(day_w));

   rtc_dhms_match #(.DAY_W(DAY_W)) u_match (
      .clk(clk), .rst_n(rst_n), .step_i(step_w), .now_i(now_w), .day_i(day_w),
      .alm_i(alm_w), .alm_day_i(aday_w), .alarm_o(alarm_o));

endmodule

// File: rtl/rtc_dhms_chk.sv
module rtc_dhms_chk
   import rtc_dhms_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              bus_sel_i,
   input logic              bus_wr_i,
   input logic [BUS_AW-1:0] bus_addr_i,
   input logic [BUS_DW-1:0] bus_wdata_i,
   input logic [BUS_DW-1:0] bus_rdata_o,
   input logic              alarm_o,
   input logic              run_i,
   input hms_t              now_i,
   input hms_t              alm_i,
   input logic [DAY_W-1:0]  day_i,
   input logic [DAY_W-1:0]  aday_i
);

   logic       wr, rd;
   logic [3:0] word;
   logic       unused_chk;

   assign wr   = bus_sel_i & bus_wr_i;
   assign rd   = bus_sel_i & ~bus_wr_i;
   assign word = bus_addr_i[BUS_AW-1:2];
   assign unused_chk = ^{bus_addr_i[1:0], bus_wdata_i[BUS_DW-1:SEC_W]};

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_i && !wr && now_i.sc < 6'd59) |=> now_i.sc == SEC_W'($past(now_i.sc) + 1)); // R2

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_i && !wr && now_i.sc >= 6'd59) |=> now_i.sc == '0); // R3

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr) |=> ($stable(now_i) && $stable(day_i))); // R6

   AST_WR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && word == W_SEC) |=> now_i.sc == $past(bus_wdata_i[SEC_W-1:0])); // R5

   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> bus_rdata_o == '0); // R4

   AST_ALARM_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |-> (now_i == alm_i && day_i == aday_i)); // R8

   AST_ALARM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |=> !alarm_o); // R9

endmodule

bind rtc_dhms_core rtc_dhms_chk #(.DAY_W(DAY_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel_i(bus_sel_i),
   .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
   .bus_rdata_o(bus_rdata_o), .alarm_o(alarm_o), .run_i(run_w),
   .now_i(now_w), .alm_i(alm_w), .day_i(day_w), .aday_i(aday_w));

// File: tb/rtc_dhms_core_tb_top.sv
`timescale 1ns/1ps
module rtc_dhms_core_tb_top;

   localparam int DAY_W = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_i, bus_sel_i, bus_wr_i;
   logic [5:0]  bus_addr_i;
   logic [15:0] bus_wdata_i;
   logic [15:0] bus_rdata_o;
   logic [1:0]  rate_sel_o;
   logic        alarm_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   // behavioural reference state
   int m_sc, m_mn, m_hr, m_dy;
   int a_sc, a_mn, a_hr, a_dy;
   int m_run, m_rate, m_adv;

   always #4 clk = ~clk;

   rtc_dhms_core #(.DAY_W(DAY_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel_i(bus_sel_i),
      .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .rate_sel_o(rate_sel_o), .alarm_o(alarm_o));

   function automatic logic [15:0] model_read(input logic [5:0] a);
      case (a[5:2])
         4'h0: return 16'((m_hr << 8) | m_mn);
         4'h1: return 16'(m_sc);
         4'h2: return 16'((a_hr << 8) | a_mn);
         4'h3: return 16'(a_sc);
         4'h4: return 16'((m_run << 7) | (m_rate << 5));
         4'h8: return 16'(m_dy);
         4'h9: return 16'(a_dy);
         default: return 16'h0;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_sc = 0; m_mn = 0; m_hr = 0; m_dy = 0;
      a_sc = 0; a_mn = 0; a_hr = 0; a_dy = 0;
      m_run = 0; m_rate = 0; m_adv = 0;
   endtask

   task automatic model_edge(input logic t, input logic s, input logic w,
                             input logic [5:0] a, input logic [15:0] d);
      bit twr;
      twr = s && w && (a[5:2] == 4'h0 || a[5:2] == 4'h1 || a[5:2] == 4'h8);
      if (s && w) begin
         case (a[5:2])
            4'h0: begin m_hr = int'(d[12:8]); m_mn = int'(d[5:0]); end
            4'h1: m_sc = int'(d[5:0]);
            4'h2: begin a_hr = int'(d[12:8]); a_mn = int'(d[5:0]); end
            4'h3: a_sc = int'(d[5:0]);
            4'h4: begin m_run = int'(d[7]); m_rate = int'(d[6:5]); end
            4'h8: m_dy = int'(d[DAY_W-1:0]);
            4'h9: a_dy = int'(d[DAY_W-1:0]);
            default: ;
         endcase
      end
      m_adv = (!twr && t && m_run != 0) ? 1 : 0;
      if (m_adv != 0) begin
         if (m_sc >= 59) begin
            m_sc = 0;
            if (m_mn >= 59) begin
               m_mn = 0;
               if (m_hr >= 23) begin
                  m_hr = 0;
                  m_dy = (m_dy + 1) % (1 << DAY_W);
               end else m_hr++;
            end else m_mn++;
         end else m_sc++;
      end
   endtask

   // one cycle: drive after falling edge, check outputs mid-cycle, step model at rising edge
   task automatic cyc(input logic t, input logic s, input logic w,
                      input logic [5:0] a, input logic [15:0] d, input string tag);
      int exp_alarm;
      tick_i = t; bus_sel_i = s; bus_wr_i = w; bus_addr_i = a; bus_wdata_i = d;
      #1;
      exp_alarm = (m_adv != 0 && m_sc == a_sc && m_mn == a_mn && m_hr == a_hr && m_dy == a_dy) ? 1 : 0;
      check(tag, "rdata", int'(bus_rdata_o), (s && !w) ? int'(model_read(a)) : 0);
      check(tag, "alarm_o", int'(alarm_o), exp_alarm);
      check(tag, "rate_sel_o", int'(rate_sel_o), m_rate);
      @(posedge clk);
      model_edge(t, s, w, a, d);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
      cyc(1'b0, 1'b1, 1'b1, a, d, tag);
   endtask
   task automatic rd(input logic [5:0] a, input string tag);
      cyc(1'b0, 1'b1, 1'b0, a, 16'h0, tag);
   endtask
   task automatic tk(input string tag);
      cyc(1'b1, 1'b0, 1'b0, 6'h0, 16'h0, tag);
   endtask
   task automatic rd_all(input string tag);
      rd(6'h00, tag); rd(6'h04, tag); rd(6'h20, tag);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick_i = 0; bus_sel_i = 0; bus_wr_i = 0;
      bus_addr_i = '0; bus_wdata_i = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, R4: full decode including holes
      for (int i = 0; i < 16; i++) rd(6'(i * 4), "R1");
      rd(6'h13, "R4");
      cyc(1'b0, 1'b0, 1'b0, 6'h04, 16'h0, "R4");

      // R6: ticks ignored while the run enable is clear
      repeat (3) tk("R6");
      rd_all("R6");

      // R7: control stores only bits 7 and 6:5
      wr(6'h10, 16'hFFFF, "R7");
      rd(6'h10, "R7");
      wr(6'h10, 16'h0020, "R7");
      rd(6'h10, "R7");
      wr(6'h10, 16'h0080, "R7");

      // R2: seconds advance one per tick, idle cycles hold
      repeat (5) tk("R2");
      cyc(1'b0, 1'b0, 1'b0, 6'h0, 16'h0, "R2");
      rd_all("R2");

      // R3 / R10: full carry through every field and day wrap at DAY_W
      wr(6'h04, 16'd58, "R5");
      wr(6'h00, 16'h173B, "R5");
      wr(6'h20, 16'hFFFF, "R10");
      rd_all("R5");
      tk("R3"); rd_all("R3");
      tk("R3"); rd_all("R10");

      // R3: out-of-range minute rolls over at the limit check
      wr(6'h00, 16'h053E, "R3");
      wr(6'h04, 16'd59, "R3");
      tk("R3"); rd_all("R3");

      // R5: write collides with a tick; tick is dropped, no carry
      cyc(1'b1, 1'b1, 1'b1, 6'h04, 16'd59, "R5");
      rd_all("R5");
      cyc(1'b1, 1'b1, 1'b1, 6'h00, 16'h0102, "R5");
      rd_all("R5");

      // R6: disable again, ticks frozen
      wr(6'h10, 16'h0000, "R6");
      repeat (2) tk("R6");
      rd_all("R6");
      wr(6'h10, 16'h0080, "R6");

      // R8/R9: alarm on the tick that brings all four fields equal
      wr(6'h24, 16'd3, "R8");
      wr(6'h08, 16'h0A14, "R8");
      wr(6'h0C, 16'd30, "R8");
      wr(6'h20, 16'd3, "R8");
      wr(6'h00, 16'h0A14, "R8");
      wr(6'h04, 16'd29, "R8");
      tk("R9");
      cyc(1'b0, 1'b0, 1'b0, 6'h0, 16'h0, "R9");
      cyc(1'b0, 1'b0, 1'b0, 6'h0, 16'h0, "R9");

      // R9: equality reached by a write only, no pulse
      wr(6'h0C, 16'd30, "R9");
      cyc(1'b0, 1'b0, 1'b0, 6'h0, 16'h0, "R9");
      wr(6'h0C, 16'd31, "R9");
      cyc(1'b0, 1'b0, 1'b0, 6'h0, 16'h0, "R9");

      // R8: day mismatch alone blocks the alarm
      wr(6'h24, 16'd4, "R8");
      wr(6'h04, 16'd29, "R8");
      tk("R8"); tk("R8");
      cyc(1'b0, 1'b0, 1'b0, 6'h0, 16'h0, "R8");
      rd(6'h24, "R8");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule